// File: doc/BRIEF.md
# GF(2^8) Weighted Parity Engine

This block computes storage-array parity over a group of equal-length source streams. For every byte position it forms P, the XOR of all source bytes, and Q, the XOR of every source byte multiplied in GF(2^8) by a per-source 8-bit weight. The result appears on one or two destination byte streams, depending on the operation chosen in the command. Fetching data from memory and parsing descriptors are handled elsewhere. This block sees a command, then a stream of source bytes, one source after another within each byte position.

The engine also folds an earlier partial result into a new pass. This lets a large stripe be built up over several commands. The reduction polynomial of the field is held in a writable register. Each command keeps the polynomial value that was present when it was accepted. Multiplication runs through a pipelined shift-and-reduce chain that takes one source byte per clock.

Top module: `pq_parity_engine`

## Requirements
- R1: Operations 01, 10 and 11 take 2 to 16 sources, and `cmd_cnt_m1` carries the source count minus one. A command with `cmd_cnt_m1` = 0 is refused: `cmd_reject` pulses one cycle after the command, and the engine stays idle with `cmd_ready` = 1 and `src_ready` = 0.
- R2: Operation 00 (copy) takes exactly one source byte per position and emits it on `p_data`. It ignores `cmd_cnt_m1` and `cmd_cont`.
- R3: Operation 01 (XOR) emits the XOR of all source bytes of a position on `p_data`, and `q_valid` stays low.
- R4: Operation 10 (Q only) emits the GF(2^8) sum of coef[i]·src[i] on `q_data`, where coef[i] is `cmd_coef_q[8i+7:8i]`. `p_valid` stays low.
- R5: Operation 11 (P and Q) emits the XOR of the sources on `p_data` and the weighted sum on `q_data`, with `p_valid` and `q_valid` raised in the same cycle.
- R6: The polynomial register resets to 0x1D, which stands for x^8+x^4+x^3+x^2+1. A `poly_wr` writes `poly_wdata` into it. A command uses the value held in its acceptance cycle, even if the register is written while the command runs.
- R7: A lone source supplied twice, with weight 0 on the second copy, yields Q = coef[0]·src.
- R8: With `cmd_cont` = 1 on operation 11, three extra bytes follow the real sources of each position, in the order old P, old Q, old Q. The new P is XOR(sources)^oldP, and the new Q is the weighted sum ^ oldQ.
- R9: With `cmd_cont` = 1 on operation 10, one extra byte (old Q) follows the real sources. The new Q is the weighted sum ^ oldQ.
- R10: `cmd_cont` has no effect on operations 00 and 01. No extra bytes are taken.
- R11: A command is refused with `cmd_reject` if any of the following holds: its length is 0, its length exceeds 1,048,576 bytes, or the real plus appended source count exceeds 16. A length of exactly 1,048,576 is accepted.
- R12: A position's result appears exactly 8 cycles after the clock edge that accepts its last source byte. `src_ready` is high while bytes of the command remain. `cmd_ready` returns high in the cycle after the last byte is accepted.
- R13: Source bytes offered while the engine is idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poly_wr | input | 1 | Write strobe for the polynomial register |
| poly_wdata | input | 8 | Low 8 bits of the field polynomial |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, a command may be taken |
| cmd_op | input | 2 | 00 copy, 01 XOR, 10 Q only, 11 P and Q |
| cmd_cnt_m1 | input | 4 | Real source count minus one |
| cmd_cont | input | 1 | Fold a previous partial result |
| cmd_len | input | 21 | Byte positions per source |
| cmd_coef_q | input | 128 | Q weights, source i in bits [8i+7:8i] |
| cmd_reject | output | 1 | One-cycle pulse: command refused |
| src_valid | input | 1 | Source byte offered |
| src_ready | output | 1 | Source byte taken when valid |
| src_data | input | 8 | Source byte |
| p_valid | output | 1 | P result strobe |
| p_data | output | 8 | P result byte |
| q_valid | output | 1 | Q result strobe |
| q_data | output | 8 | Q result byte |

## Verification
The internal source index selects both the weight and the group boundary. If it slips, every later position emits a corrupt P or Q, or a strobe that comes early or late. The bench sees this within 8 cycles of the affected byte. A wrong polynomial snapshot or weight selection corrupts only Q, and it does so in the first position that uses a weight bit needing reduction. An error in the byte counter shows as `cmd_ready` returning too early or too late at the end of a command, so the bench compares the strobes every clock as well as the data.

// File: rtl/pq_pkg.sv
// Package: shared types and field helpers for the parity engine.
// Assumes GF(2^8) arithmetic with the x^8 term implicit in the polynomial.
package pq_pkg;
    localparam int GF_W = 8;

    typedef enum logic [1:0] {
        OP_COPY  = 2'b00,
        OP_XOR   = 2'b01,
        OP_QONLY = 2'b10,
        OP_PQ    = 2'b11
    } op_e;

    // One source byte travelling through the multiplier chain.
    typedef struct packed {
        logic            valid;
        logic            first;
        logic            last;
        logic            has_p;
        logic            has_q;
        logic [GF_W-1:0] poly;
        logic [GF_W-1:0] a;
        logic [GF_W-1:0] b;
        logic [GF_W-1:0] prod;
        logic [GF_W-1:0] pbyte;
    } lane_t;

    // Finished product handed to the accumulator.
    typedef struct packed {
        logic            valid;
        logic            first;
        logic            last;
        logic            has_p;
        logic            has_q;
        logic [GF_W-1:0] prod;
        logic [GF_W-1:0] pbyte;
    } res_t;

    // Multiply by x and reduce once.
    function automatic logic [GF_W-1:0] gf_xtime(input logic [GF_W-1:0] v,
                                                 input logic [GF_W-1:0] poly);
        gf_xtime = {v[GF_W-2:0], 1'b0} ^ (v[GF_W-1] ? poly : '0);
    endfunction

    // One shift-and-add step: fold the low weight bit, advance operand and weight.
    function automatic lane_t gf_step(input lane_t in);
        lane_t o;
        o      = in;
        o.prod = in.prod ^ (in.b[0] ? in.a : '0);
        o.a    = gf_xtime(in.a, in.poly);
        o.b    = in.b >> 1;
        return o;
    endfunction
endpackage

// File: rtl/pq_seq.sv
// Command sequencer: validates and captures a command and holds the
// polynomial register. It walks the source index and byte count, selects
// the Q weight of each incoming byte (appended continuation sources
// included) and emits one lane per accepted byte.
// Assumes source bytes of a position arrive in source order.
module pq_seq
    import pq_pkg::*;
#(
    parameter int          MAX_SRC  = 16,
    parameter int          MAX_LEN  = 1 << 20,
    parameter logic [7:0]  POLY_RST = 8'h1D
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             poly_wr,
    input  logic [GF_W-1:0]                  poly_wdata,
    input  logic                             cmd_valid,
    output logic                             cmd_ready,
    input  logic [1:0]                       cmd_op,
    input  logic [$clog2(MAX_SRC)-1:0]       cmd_cnt_m1,
    input  logic                             cmd_cont,
    input  logic [$clog2(MAX_LEN):0]         cmd_len,
    input  logic [MAX_SRC*GF_W-1:0]          cmd_coef_q,
    output logic                             cmd_reject,
    input  logic                             src_valid,
    output logic                             src_ready,
    input  logic [GF_W-1:0]                  src_data,
    output lane_t                            lane_o
);
    localparam int IDX_W = $clog2(MAX_SRC);
    localparam int TOT_W = IDX_W + 2;
    localparam int LEN_W = $clog2(MAX_LEN) + 1;

    op_e                          op_in;
    logic [TOT_W-1:0]             n_real, n_extra, n_total;
    logic                         bad;
    logic [GF_W-1:0]              poly_q, op_poly;
    logic                         busy;
    op_e                          op_r;
    logic [IDX_W-1:0]             idx, last_idx;
    logic [TOT_W-1:0]             nreal_r, app_k;
    logic [MAX_SRC-1:0][GF_W-1:0] coef_r;
    logic [LEN_W-1:0]             rem;
    logic                         accept, beat, at_last;
    logic [GF_W-1:0]              qc;

    assign op_in = op_e'(cmd_op);

    // Decode the source count a command implies, continuation included.
    always_comb begin
        n_real  = TOT_W'(cmd_cnt_m1) + TOT_W'(1);
        n_extra = '0;
        if (cmd_cont && op_in == OP_PQ)    n_extra = TOT_W'(3);
        if (cmd_cont && op_in == OP_QONLY) n_extra = TOT_W'(1);
        n_total = (op_in == OP_COPY) ? TOT_W'(1) : n_real + n_extra;
        bad = (cmd_len == '0) || (cmd_len > LEN_W'(MAX_LEN)) ||
              (op_in != OP_COPY && cmd_cnt_m1 == '0) ||
              (n_total > TOT_W'(MAX_SRC));
    end

    assign cmd_ready = !busy;
    assign src_ready = busy;
    assign accept    = cmd_valid && !busy && !bad;
    assign beat      = src_valid && busy;
    assign at_last   = (idx == last_idx);
    assign app_k     = TOT_W'(idx) - nreal_r;

    // Holds the field polynomial register.
    always_ff @(posedge clk) begin
        if (!rst_n)       poly_q <= POLY_RST;
        else if (poly_wr) poly_q <= poly_wdata;
    end

    // Captures a command, then steps the source index and byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cmd_reject <= 1'b0;
            op_r       <= OP_COPY;
            idx        <= '0;
            last_idx   <= '0;
            nreal_r    <= '0;
            coef_r     <= '0;
            rem        <= '0;
            op_poly    <= '0;
        end else begin
            cmd_reject <= cmd_valid && !busy && bad;
            if (accept) begin
                busy     <= 1'b1;
                op_r     <= op_in;
                idx      <= '0;
                last_idx <= IDX_W'(n_total - TOT_W'(1));
                nreal_r  <= n_real;
                coef_r   <= cmd_coef_q;
                rem      <= cmd_len;
                op_poly  <= poly_q;
            end else if (beat) begin
                if (at_last) begin
                    idx <= '0;
                    rem <= rem - LEN_W'(1);
                    if (rem == LEN_W'(1)) busy <= 1'b0;
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end

    // Selects the Q weight of the byte at the current source index.
    always_comb begin
        if (TOT_W'(idx) < nreal_r)  qc = coef_r[idx];
        else if (op_r == OP_PQ)     qc = (app_k == TOT_W'(2)) ? 8'h01 : 8'h00;
        else                        qc = 8'h01;
    end

    // Builds the lane for the byte taken in this cycle.
    always_comb begin
        lane_o.valid = beat;
        lane_o.first = (idx == '0);
        lane_o.last  = at_last;
        lane_o.has_p = (op_r != OP_QONLY);
        lane_o.has_q = op_r[1];
        lane_o.poly  = op_poly;
        lane_o.a     = src_data;
        lane_o.b     = qc;
        lane_o.prod  = '0;
        lane_o.pbyte = src_data;
    end

    assert_idx_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> idx <= last_idx);
    assert_rem_live_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rem != '0);
    assert_poly_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(op_poly));
    assert_reject_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> !busy);
endmodule

// File: rtl/pq_gf_pipe.sv
// Multiplier chain: one shift-and-add bit step per register stage, so a
// new byte/weight pair enters every clock. The chain has GF_W stages of
// latency and carries the P byte and the group flags alongside.
// Assumes the weight arrives in lane.b and the polynomial in lane.poly.
module pq_gf_pipe
    import pq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  lane_t lane_i,
    output res_t  res_o
);
    lane_t tail;
    logic [GF_W-1:0] prod_f;

    genvar g;
    for (g = 0; g < GF_W - 1; g++) begin : g_stage
        lane_t src;
        lane_t q;
        if (g == 0) begin : g_head
            assign src = lane_i;
        end else begin : g_body
            assign src = g_stage[g-1].q;
        end
        // Registers one bit step of the product.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= gf_step(src);
        end
    end

    assign tail   = g_stage[GF_W-2].q;
    assign prod_f = tail.prod ^ (tail.b[0] ? tail.a : '0);

    // Folds the top weight bit and registers the finished product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o <= '0;
        end else begin
            res_o.valid <= tail.valid;
            res_o.first <= tail.first;
            res_o.last  <= tail.last;
            res_o.has_p <= tail.has_p;
            res_o.has_q <= tail.has_q;
            res_o.prod  <= prod_f;
            res_o.pbyte <= tail.pbyte;
        end
    end

    assert_coef_drained_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tail.valid |-> tail.b[GF_W-1:1] == '0);
endmodule

// File: rtl/pq_accum.sv
// Accumulator: XORs the products and P bytes of one byte position,
// starting afresh on the first source, and drives the result strobes
// after the last one. Assumes groups arrive whole and in order.
module pq_accum
    import pq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  res_t            res_i,
    output logic            p_valid,
    output logic [GF_W-1:0] p_data,
    output logic            q_valid,
    output logic [GF_W-1:0] q_data
);
    logic [GF_W-1:0] acc_p, acc_q, nxt_p, nxt_q;
    logic            open;

    assign nxt_p = res_i.first ? res_i.pbyte : (acc_p ^ res_i.pbyte);
    assign nxt_q = res_i.first ? res_i.prod  : (acc_q ^ res_i.prod);

    // Accumulates a position and emits it on the closing byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_p   <= '0;
            acc_q   <= '0;
            open    <= 1'b0;
            p_valid <= 1'b0;
            q_valid <= 1'b0;
            p_data  <= '0;
            q_data  <= '0;
        end else begin
            p_valid <= 1'b0;
            q_valid <= 1'b0;
            if (res_i.valid) begin
                acc_p <= nxt_p;
                acc_q <= nxt_q;
                open  <= !res_i.last;
                if (res_i.last) begin
                    p_valid <= res_i.has_p;
                    q_valid <= res_i.has_q;
                    p_data  <= nxt_p;
                    q_data  <= nxt_q;
                end
            end
        end
    end

    assert_first_closed_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_i.valid && res_i.first) |-> !open);
    assert_mid_open_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_i.valid && !res_i.first) |-> open);
endmodule

// File: rtl/pq_parity_engine.sv
// Top level of the parity engine: sequencer, multiplier chain and
// accumulator in series. Results follow the last source byte of a
// position by a fixed 8 cycles.
module pq_parity_engine
    import pq_pkg::*;
#(
    parameter int         MAX_SRC  = 16,
    parameter int         MAX_LEN  = 1 << 20,
    parameter logic [7:0] POLY_RST = 8'h1D
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        poly_wr,
    input  logic [7:0]                  poly_wdata,
    input  logic                        cmd_valid,
    output logic                        cmd_ready,
    input  logic [1:0]                  cmd_op,
    input  logic [$clog2(MAX_SRC)-1:0]  cmd_cnt_m1,
    input  logic                        cmd_cont,
    input  logic [$clog2(MAX_LEN):0]    cmd_len,
    input  logic [MAX_SRC*8-1:0]        cmd_coef_q,
    output logic                        cmd_reject,
    input  logic                        src_valid,
    output logic                        src_ready,
    input  logic [7:0]                  src_data,
    output logic                        p_valid,
    output logic [7:0]                  p_data,
    output logic                        q_valid,
    output logic [7:0]                  q_data
);
    lane_t lane;
    res_t  res;

    pq_seq #(.MAX_SRC(MAX_SRC), .MAX_LEN(MAX_LEN), .POLY_RST(POLY_RST)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .poly_wr(poly_wr), .poly_wdata(poly_wdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_cnt_m1(cmd_cnt_m1), .cmd_cont(cmd_cont), .cmd_len(cmd_len),
        .cmd_coef_q(cmd_coef_q), .cmd_reject(cmd_reject),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .lane_o(lane)
    );

    pq_gf_pipe u_pipe (
        .clk(clk), .rst_n(rst_n), .lane_i(lane), .res_o(res)
    );

    pq_accum u_acc (
        .clk(clk), .rst_n(rst_n), .res_i(res),
        .p_valid(p_valid), .p_data(p_data),
        .q_valid(q_valid), .q_data(q_data)
    );
endmodule

// File: tb/tb_pq_parity_engine.sv
module tb_pq_parity_engine;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         poly_wr = 1'b0;
    logic [7:0]   poly_wdata = 8'h00;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [1:0]   cmd_op = 2'b00;
    logic [3:0]   cmd_cnt_m1 = 4'h0;
    logic         cmd_cont = 1'b0;
    logic [20:0]  cmd_len = '0;
    logic [127:0] cmd_coef_q = '0;
    logic         cmd_reject;
    logic         src_valid = 1'b0;
    logic         src_ready;
    logic [7:0]   src_data = 8'h00;
    logic         p_valid, q_valid;
    logic [7:0]   p_data, q_data;

    always #10ns clk = ~clk;

    pq_parity_engine dut (
        .clk(clk), .rst_n(rst_n), .poly_wr(poly_wr), .poly_wdata(poly_wdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_cnt_m1(cmd_cnt_m1), .cmd_cont(cmd_cont), .cmd_len(cmd_len),
        .cmd_coef_q(cmd_coef_q), .cmd_reject(cmd_reject),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .p_valid(p_valid), .p_data(p_data), .q_valid(q_valid), .q_data(q_data)
    );

    typedef struct {
        int         due;
        bit         hp;
        bit         hq;
        logic [7:0] p;
        logic [7:0] q;
        string      tag;
    } exp_t;

    exp_t       expq[$];
    int         cyc = 0;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;
    logic [7:0] cur_poly = 8'h1D;
    logic [7:0] coef [16];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // GF(2^8) product by carry-less multiply and long division by {1,poly}.
    function automatic logic [7:0] gmul(input logic [7:0] x, input logic [7:0] y,
                                        input logic [7:0] poly);
        logic [15:0] acc;
        acc = '0;
        for (int k = 0; k < 8; k++) if (y[k]) acc ^= (16'(x) << k);
        for (int k = 15; k >= 8; k--)
            if (acc[k]) acc ^= (16'({1'b1, poly}) << (k - 8));
        return acc[7:0];
    endfunction

    function automatic logic [7:0] bval(input int seed, input int pos, input int i);
        int h;
        h = seed * 131 + pos * 31 + i * 7 + 17;
        h = h ^ (h >>> 3) ^ (h * 37);
        return h[7:0];
    endfunction

    // Reference model: per-cycle strobe and data comparison.
    always @(negedge clk) begin
        exp_t e;
        bit ep, eqv;
        logic [7:0] xp, xq;
        string t;
        if (rst_n) begin
            ep = 0; eqv = 0; xp = 0; xq = 0; t = "R12";
            if (expq.size() > 0 && expq[0].due == cyc) begin
                e = expq.pop_front();
                ep = e.hp; eqv = e.hq; xp = e.p; xq = e.q; t = e.tag;
            end
            check(p_valid === ep, t, "p_valid", p_valid, ep);
            check(q_valid === eqv, t, "q_valid", q_valid, eqv);
            if (ep)  check(p_data === xp, t, "p_data", p_data, xp);
            if (eqv) check(q_data === xq, t, "q_data", q_data, xq);
        end
    end

    task automatic run_op(input logic [1:0] op, input int nreal, input bit cont,
                          input int len, input int seed, input bit dup,
                          input bit poly_mid, input string tag);
        logic [7:0] opoly;
        int nsrc, nbeats;
        opoly  = cur_poly;
        nsrc   = (op == 2'b00) ? 1 : nreal;
        nbeats = nsrc + ((cont && op == 2'b11) ? 3 : (cont && op == 2'b10) ? 1 : 0);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_cnt_m1 = 4'(nreal - 1);
        cmd_cont = cont; cmd_len = 21'(len);
        for (int i = 0; i < 16; i++) cmd_coef_q[i*8 +: 8] = coef[i];
        @(negedge clk);
        cmd_valid = 0;
        check(cmd_ready == 1'b0 && cmd_reject == 1'b0, tag, "command taken",
              {cmd_ready, cmd_reject}, 0);
        for (int pos = 0; pos < len; pos++) begin
            logic [7:0] xp, xq, oldp, oldq;
            xp = 0; xq = 0;
            oldp = bval(seed + 1, pos, 0);
            oldq = bval(seed + 2, pos, 0);
            for (int i = 0; i < nbeats; i++) begin
                logic [7:0] d;
                if (i < nsrc) begin
                    d = (dup && i == 1) ? bval(seed, pos, 0) : bval(seed, pos, i);
                    xp ^= d;
                    xq ^= gmul(d, coef[i], opoly);
                end else if (op == 2'b11 && i == nsrc) begin
                    d = oldp;
                end else begin
                    d = oldq;
                end
                if (((pos * 7 + i * 3 + seed) % 6) == 5) begin
                    src_valid = 0;
                    @(negedge clk);
                end
                src_valid = 1; src_data = d;
                if (poly_mid && pos == 0 && i == 0) begin
                    poly_wr = 1; poly_wdata = 8'h2B;
                end
                if (i == nbeats - 1) begin
                    if (cont && op == 2'b11) xp ^= oldp;
                    if (cont && op[1]) xq ^= oldq;
                    expq.push_back('{cyc + 9, op != 2'b10, op[1], xp, xq, tag});
                end
                @(negedge clk);
                if (poly_wr) begin poly_wr = 0; cur_poly = 8'h2B; end
            end
        end
        src_valid = 0;
        check(cmd_ready == 1'b1 && src_ready == 1'b0, "R12", "idle after last byte",
              {cmd_ready, src_ready}, 2);
    endtask

    task automatic try_reject(input logic [1:0] op, input int cnt_m1, input bit cont,
                              input int len, input string tag);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_cnt_m1 = 4'(cnt_m1);
        cmd_cont = cont; cmd_len = 21'(len);
        @(negedge clk);
        cmd_valid = 0;
        check(cmd_reject == 1'b1, tag, "cmd_reject", cmd_reject, 1);
        check(cmd_ready == 1'b1 && src_ready == 1'b0, tag, "idle after refusal",
              {cmd_ready, src_ready}, 2);
    endtask

    task automatic drain();
        repeat (12) @(negedge clk);
    endtask

    initial begin
        #3ms;
        if (!done) begin
            checks++; fails++;
            $display("FAIL R12 watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) coef[i] = 8'((i * 29 + 3) & 8'hFF);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(cmd_ready == 1 && src_ready == 0 && cmd_reject == 0, "R12", "reset state",
              {cmd_ready, src_ready, cmd_reject}, 4);

        run_op(2'b00, 5, 1'b1, 3, 1, 0, 0, "R2");        // copy, count and cont ignored
        run_op(2'b01, 4, 1'b0, 4, 2, 0, 0, "R3");
        run_op(2'b01, 3, 1'b1, 3, 3, 0, 0, "R10");       // cont ignored on XOR
        run_op(2'b10, 16, 1'b0, 3, 4, 0, 0, "R4");       // 16 sources, reset polynomial
        run_op(2'b11, 2, 1'b0, 5, 5, 0, 0, "R5");        // minimum two sources (R1)
        coef[1] = 8'h00;
        run_op(2'b10, 2, 1'b0, 4, 6, 1, 0, "R7");
        coef[1] = 8'h20;
        run_op(2'b11, 4, 1'b1, 3, 7, 0, 0, "R8");
        run_op(2'b10, 5, 1'b1, 3, 8, 0, 0, "R9");
        run_op(2'b10, 3, 1'b0, 3, 9, 0, 1, "R6");        // write mid-command
        run_op(2'b11, 3, 1'b0, 3, 10, 0, 0, "R6");       // next command sees new value
        drain();

        try_reject(2'b01, 0, 1'b0, 4, "R1");
        try_reject(2'b11, 0, 1'b0, 4, "R1");
        try_reject(2'b01, 3, 1'b0, 0, "R11");
        try_reject(2'b01, 3, 1'b0, 1048577, "R11");
        try_reject(2'b11, 13, 1'b1, 4, "R11");
        try_reject(2'b10, 15, 1'b1, 4, "R11");

        src_valid = 1; src_data = 8'h5A;                  // stray bytes while idle
        repeat (3) @(negedge clk);
        src_valid = 0;
        run_op(2'b11, 3, 1'b0, 2, 11, 0, 0, "R13");
        drain();

        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'b01; cmd_cnt_m1 = 4'd1; cmd_cont = 0; cmd_len = 21'd1048576;
        @(negedge clk);
        cmd_valid = 0;
        check(cmd_ready == 0 && cmd_reject == 0, "R11", "1 MiB taken",
              {cmd_ready, cmd_reject}, 0);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        cur_poly = 8'h1D;
        @(negedge clk);
        check(cmd_ready == 1 && src_ready == 0, "R12", "state after reset",
              {cmd_ready, src_ready}, 2);
        run_op(2'b10, 4, 1'b0, 2, 12, 0, 0, "R6");       // polynomial back to 0x1D
        drain();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule